// File: doc/BRIEF.md
# AUX Request to I2C Bridge

This block serves one display-link auxiliary-channel request at a time. A request carries a 4-bit command, a 20-bit address, a byte count of up to 16, and a 16-byte data buffer. The command decides where the request goes. It can run as a series of single-byte accesses against a 1 MiB native register space. Otherwise it becomes a series of start, byte-transfer and stop operations on an I2C controller command port. Each request ends with exactly one reply code.

I2C requests come in two kinds, plain and middle-of-transaction (MOT). A plain I2C request always leaves the bus closed when it finishes. A MOT request leaves the bus transaction open so that the next MOT request can go on with no new start. The bridge remembers the address and command of the last MOT request that opened or continued the transaction. It issues a stop followed by a new start only when a later MOT request differs from it in either field.

The command encoding is as follows:
- Bit 3 = 1 selects native and 0 selects I2C.
- Bits 1:0 select the direction: 00 = write, 01 = read.
- Bit 2 marks MOT and is legal only when bit 3 = 0.

Reply codes are 00 = ACK, 01 = NACK and 10 = DEFER.

Top module: `aux_i2c_bridge`

## Requirements
- R1: The only recognised commands are 0x0, 0x1, 0x4, 0x5, 0x8 and 0x9. Every other command code replies 01 (NACK) one cycle after acceptance. It raises neither `i2c_req` nor `nat_req`.
- R2: A native request (0x8 write, 0x9 read) of length N issues N single-byte accesses, one after another. The accesses go to addresses A, A+1, …, A+N-1, modulo 2^20. Write bytes come from `req_wdata[8i+:8]`, and read bytes are returned in `rsp_rdata[8i+:8]`. When all N accesses succeed the reply is 00.
- R3: A native access that returns `nat_err` ends the request. No further access is issued, and the reply is 01.
- R4: A native request with length 0 replies 01 and issues no access.
- R5: A plain I2C request (0x0 write, 0x1 read) first issues a stop if a transaction is open. It then issues a start with the address bits [6:0] and the direction. If the start is not acknowledged, the reply is 01 and no stop follows.
- R6: After a successful start, a plain request transfers its bytes in order. A byte that is not acknowledged ends the byte loop. A stop is always issued at the end. The reply is 00 only if every byte was acknowledged, and 01 otherwise. Read bytes are returned in `rsp_rdata`.
- R7: A MOT request (0x4 write, 0x5 read) with no open transaction issues a start. A failed start replies 01 and leaves the bus closed.
- R8: A MOT request with an open transaction issues a stop and then a start only when its full 20-bit address or its command differs from the stored ones. Otherwise it goes straight to the byte transfers.
- R9: A MOT request whose bytes all succeed replies 00 and issues no stop, so the transaction stays open. A failed MOT byte issues a stop, replies 01 and closes the transaction.
- R10: `req_ready` is high only while the bridge is idle. Each accepted request produces exactly one `rsp_valid` pulse, and `rsp_code` is never 10 (DEFER). `i2c_req` and `nat_req` are never high in the same cycle. Out of reset, `req_ready` is 1 and every request and reply strobe is 0.
- R11: Native and unrecognised requests do not change the open-transaction state, or the stored address and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle; a request is taken when valid and ready are both high |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Native address, or I2C target address in bits [6:0] |
| req_len | input | 5 | Byte count; values above 16 are treated as 16 |
| req_wdata | input | 128 | Write buffer, byte i at [8i+:8] |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_code | output | 2 | Reply: 00 ACK, 01 NACK |
| rsp_rdata | output | 128 | Buffer after the request, read bytes at [8i+:8] |
| i2c_req | output | 1 | One-cycle I2C operation strobe |
| i2c_op | output | 2 | 0 start, 1 byte transfer, 2 stop |
| i2c_addr | output | 7 | Target address for a start |
| i2c_rd | output | 1 | Direction, 1 = read |
| i2c_wdata | output | 8 | Byte to send on a write transfer |
| i2c_done | input | 1 | Operation finished (one-cycle pulse) |
| i2c_ack | input | 1 | Start or byte acknowledged, valid with done |
| i2c_rdata | input | 8 | Byte received, valid with done |
| nat_req | output | 1 | One-cycle native access strobe |
| nat_we | output | 1 | Native write when 1 |
| nat_addr | output | 20 | Native byte address |
| nat_wdata | output | 8 | Native write byte |
| nat_done | input | 1 | Native access finished (one-cycle pulse) |
| nat_err | input | 1 | Access error, valid with done |
| nat_rdata | input | 8 | Native read byte, valid with done |

## Verification
The assertions check the following on every cycle:
- Unknown commands and zero-length native requests are answered at once.
- An access error or a refused start always leads to a NACK on the next cycle.
- A refused byte is always followed by a stop.
- Native addresses always step by one.
- The two command ports are never used together.
- DEFER never appears.

The open-transaction policy can only be shown by the bench's request sequences. These include restart or no restart by address and by command, a native request between two MOT requests, and the closed state after a failed MOT byte. The bench compares the exact logged I2C operation sequence, and the returned data, against sequences it builds itself.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;

  typedef enum logic [1:0] {
    K_NATIVE = 2'd0,
    K_PLAIN  = 2'd1,
    K_MOT    = 2'd2,
    K_BAD    = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_XFER  = 2'd1,
    OP_STOP  = 2'd2
  } i2c_op_e;

  typedef struct packed {
    req_kind_e kind;
    logic      rd;
  } cmd_dec_t;

  localparam logic [1:0] RSP_ACK   = 2'b00;
  localparam logic [1:0] RSP_NACK  = 2'b01;
  localparam logic [1:0] RSP_DEFER = 2'b10;

endpackage

// File: rtl/aux_cmd_dec.sv
module aux_cmd_dec
  import aux_bridge_pkg::*;
(
  input  logic [3:0] cmd,
  output cmd_dec_t   dec
);
  // bit3: native/I2C, bit2: continue-transaction flag, bits1:0: 00 write 01 read
  always_comb begin
    dec.rd   = cmd[0];
    dec.kind = K_BAD;
    if (cmd[1] == 1'b0) begin
      if (cmd[3]) begin
        if (!cmd[2]) dec.kind = K_NATIVE;
      end else begin
        dec.kind = cmd[2] ? K_MOT : K_PLAIN;
      end
    end
  end
endmodule

// File: rtl/aux_mot_track.sv
module aux_mot_track #(
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [CMD_W-1:0]  set_cmd,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [CMD_W-1:0]  chk_cmd,
  output logic              is_open,
  output logic              same
);
  logic [ADDR_W-1:0] last_addr_q;
  logic [CMD_W-1:0]  last_cmd_q;
  logic              open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      last_addr_q <= '0;
      last_cmd_q  <= '0;
    end else if (set_en) begin
      open_q      <= 1'b1;
      last_addr_q <= set_addr;
      last_cmd_q  <= set_cmd;
    end else if (clr_en) begin
      open_q      <= 1'b0;
    end
  end

  assign is_open = open_q;
  assign same    = open_q && (chk_addr == last_addr_q) && (chk_cmd == last_cmd_q);
endmodule

// File: rtl/aux_byte_buf.sv
module aux_byte_buf #(
  parameter int NB = 16,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int BW = NB * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [BW-1:0] load_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [BW-1:0] all_data
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)                                byte_q <= '0;
      else if (load_en)                       byte_q <= load_data[b*8 +: 8];
      else if (wr_en && (wr_idx == IW'(b)))   byte_q <= wr_byte;
    end
    assign all_data[b*8 +: 8] = byte_q;
  end

  assign rd_byte = all_data[{rd_idx, 3'b000} +: 8];
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
  import aux_bridge_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int I2C_AW  = 7,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int BUF_W  = MAX_LEN * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [BUF_W-1:0]  rsp_rdata,
  output logic              i2c_req,
  output logic [1:0]        i2c_op,
  output logic [I2C_AW-1:0] i2c_addr,
  output logic              i2c_rd,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_done,
  input  logic              i2c_ack,
  input  logic [7:0]        i2c_rdata,
  output logic              nat_req,
  output logic              nat_we,
  output logic [ADDR_W-1:0] nat_addr,
  output logic [7:0]        nat_wdata,
  input  logic              nat_done,
  input  logic              nat_err,
  input  logic [7:0]        nat_rdata
);
  typedef enum logic [1:0] { S_IDLE, S_NAT, S_I2C } state_e;

  state_e            state_q;
  logic [3:0]        cur_cmd_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  cur_len_q;
  req_kind_e         cur_kind_q;
  logic              cur_rd_q;
  logic [IDX_W-1:0]  idx_q;
  i2c_op_e           pend_op_q;
  logic              restart_q;
  logic [1:0]        final_code_q;
  logic              i2c_req_q;
  logic [1:0]        i2c_op_q;
  logic [7:0]        i2c_wdata_q;
  logic              nat_req_q;
  logic              nat_we_q;
  logic [ADDR_W-1:0] nat_addr_q;
  logic [7:0]        nat_wdata_q;
  logic              rsp_valid_q;
  logic [1:0]        rsp_code_q;

  cmd_dec_t          dec;
  logic [LEN_W-1:0]  len_eff;
  logic [IDX_W-1:0]  idx_inc;
  logic              last_byte;
  logic              trk_open, trk_same, trk_set, trk_clr;
  logic              buf_load, buf_wr;
  logic [IDX_W-1:0]  buf_rd_idx;
  logic [7:0]        buf_rd_byte, buf_wr_byte;

  aux_cmd_dec u_dec (.cmd(req_cmd), .dec(dec));

  assign len_eff   = (req_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : req_len;
  assign idx_inc   = idx_q + 1'b1;
  assign last_byte = (({{(LEN_W-IDX_W){1'b0}}, idx_q} + LEN_W'(1)) == cur_len_q);

  // transaction tracking: set on an acknowledged start, cleared on a stop or a refused start
  assign trk_set = (state_q == S_I2C) && i2c_done && (pend_op_q == OP_START) && i2c_ack;
  assign trk_clr = (state_q == S_I2C) && i2c_done &&
                   ((pend_op_q == OP_STOP) || ((pend_op_q == OP_START) && !i2c_ack));

  aux_mot_track #(.ADDR_W(ADDR_W), .CMD_W(4)) u_track (
    .clk     (clk),
    .rst     (rst),
    .set_en  (trk_set),
    .set_addr(cur_addr_q),
    .set_cmd (cur_cmd_q),
    .clr_en  (trk_clr),
    .chk_addr(req_addr),
    .chk_cmd (req_cmd),
    .is_open (trk_open),
    .same    (trk_same)
  );

  assign buf_load    = (state_q == S_IDLE) && req_valid;
  assign buf_wr      = ((state_q == S_I2C) && i2c_done && (pend_op_q == OP_XFER) && cur_rd_q && i2c_ack) ||
                       ((state_q == S_NAT) && nat_done && !nat_err && cur_rd_q);
  assign buf_wr_byte = (state_q == S_NAT) ? nat_rdata : i2c_rdata;
  assign buf_rd_idx  = ((state_q == S_I2C) && (pend_op_q == OP_START)) ? '0 : idx_inc;

  aux_byte_buf #(.NB(MAX_LEN)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .load_en  (buf_load),
    .load_data(req_wdata),
    .wr_en    (buf_wr),
    .wr_idx   (idx_q),
    .wr_byte  (buf_wr_byte),
    .rd_idx   (buf_rd_idx),
    .rd_byte  (buf_rd_byte),
    .all_data (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      cur_cmd_q    <= '0;
      cur_addr_q   <= '0;
      cur_len_q    <= '0;
      cur_kind_q   <= K_BAD;
      cur_rd_q     <= 1'b0;
      idx_q        <= '0;
      pend_op_q    <= OP_START;
      restart_q    <= 1'b0;
      final_code_q <= RSP_NACK;
      i2c_req_q    <= 1'b0;
      i2c_op_q     <= '0;
      i2c_wdata_q  <= '0;
      nat_req_q    <= 1'b0;
      nat_we_q     <= 1'b0;
      nat_addr_q   <= '0;
      nat_wdata_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_code_q   <= RSP_ACK;
    end else begin
      i2c_req_q   <= 1'b0;
      nat_req_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            cur_cmd_q  <= req_cmd;
            cur_addr_q <= req_addr;
            cur_len_q  <= len_eff;
            cur_kind_q <= dec.kind;
            cur_rd_q   <= dec.rd;
            idx_q      <= '0;
            restart_q  <= 1'b0;
            unique case (dec.kind)
              K_BAD: begin
                rsp_valid_q <= 1'b1;
                rsp_code_q  <= RSP_NACK;
              end
              K_NATIVE: begin
                if (len_eff == '0) begin
                  rsp_valid_q <= 1'b1;
                  rsp_code_q  <= RSP_NACK;
                end else begin
                  nat_req_q   <= 1'b1;
                  nat_we_q    <= !dec.rd;
                  nat_addr_q  <= req_addr;
                  nat_wdata_q <= req_wdata[7:0];
                  state_q     <= S_NAT;
                end
              end
              K_PLAIN: begin
                state_q   <= S_I2C;
                i2c_req_q <= 1'b1;
                if (trk_open) begin
                  pend_op_q <= OP_STOP;
                  i2c_op_q  <= OP_STOP;
                  restart_q <= 1'b1;
                end else begin
                  pend_op_q <= OP_START;
                  i2c_op_q  <= OP_START;
                end
              end
              default: begin // K_MOT
                if (!trk_open) begin
                  state_q   <= S_I2C;
                  i2c_req_q <= 1'b1;
                  pend_op_q <= OP_START;
                  i2c_op_q  <= OP_START;
                end else if (!trk_same) begin
                  state_q   <= S_I2C;
                  i2c_req_q <= 1'b1;
                  pend_op_q <= OP_STOP;
                  i2c_op_q  <= OP_STOP;
                  restart_q <= 1'b1;
                end else if (len_eff == '0) begin
                  rsp_valid_q <= 1'b1;
                  rsp_code_q  <= RSP_ACK;
                end else begin
                  state_q     <= S_I2C;
                  i2c_req_q   <= 1'b1;
                  pend_op_q   <= OP_XFER;
                  i2c_op_q    <= OP_XFER;
                  i2c_wdata_q <= req_wdata[7:0];
                end
              end
            endcase
          end
        end

        S_NAT: begin
          if (nat_done) begin
            if (nat_err) begin
              rsp_valid_q <= 1'b1;
              rsp_code_q  <= RSP_NACK;
              state_q     <= S_IDLE;
            end else if (last_byte) begin
              rsp_valid_q <= 1'b1;
              rsp_code_q  <= RSP_ACK;
              state_q     <= S_IDLE;
            end else begin
              idx_q       <= idx_inc;
              nat_req_q   <= 1'b1;
              nat_addr_q  <= nat_addr_q + 1'b1;
              nat_wdata_q <= buf_rd_byte;
            end
          end
        end

        default: begin // S_I2C
          if (i2c_done) begin
            unique case (pend_op_q)
              OP_STOP: begin
                if (restart_q) begin
                  restart_q <= 1'b0;
                  i2c_req_q <= 1'b1;
                  pend_op_q <= OP_START;
                  i2c_op_q  <= OP_START;
                end else begin
                  rsp_valid_q <= 1'b1;
                  rsp_code_q  <= final_code_q;
                  state_q     <= S_IDLE;
                end
              end
              OP_START: begin
                if (!i2c_ack) begin
                  rsp_valid_q <= 1'b1;
                  rsp_code_q  <= RSP_NACK;
                  state_q     <= S_IDLE;
                end else if (cur_len_q == '0) begin
                  if (cur_kind_q == K_MOT) begin
                    rsp_valid_q <= 1'b1;
                    rsp_code_q  <= RSP_ACK;
                    state_q     <= S_IDLE;
                  end else begin
                    final_code_q <= RSP_ACK;
                    i2c_req_q    <= 1'b1;
                    pend_op_q    <= OP_STOP;
                    i2c_op_q     <= OP_STOP;
                  end
                end else begin
                  i2c_req_q   <= 1'b1;
                  pend_op_q   <= OP_XFER;
                  i2c_op_q    <= OP_XFER;
                  i2c_wdata_q <= buf_rd_byte;
                end
              end
              default: begin // OP_XFER
                if (!i2c_ack) begin
                  final_code_q <= RSP_NACK;
                  i2c_req_q    <= 1'b1;
                  pend_op_q    <= OP_STOP;
                  i2c_op_q     <= OP_STOP;
                end else if (last_byte) begin
                  if (cur_kind_q == K_MOT) begin
                    rsp_valid_q <= 1'b1;
                    rsp_code_q  <= RSP_ACK;
                    state_q     <= S_IDLE;
                  end else begin
                    final_code_q <= RSP_ACK;
                    i2c_req_q    <= 1'b1;
                    pend_op_q    <= OP_STOP;
                    i2c_op_q     <= OP_STOP;
                  end
                end else begin
                  idx_q       <= idx_inc;
                  i2c_req_q   <= 1'b1;
                  i2c_op_q    <= OP_XFER;
                  i2c_wdata_q <= buf_rd_byte;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign i2c_req   = i2c_req_q;
  assign i2c_op    = i2c_op_q;
  assign i2c_addr  = cur_addr_q[I2C_AW-1:0];
  assign i2c_rd    = cur_rd_q;
  assign i2c_wdata = i2c_wdata_q;
  assign nat_req   = nat_req_q;
  assign nat_we    = nat_we_q;
  assign nat_addr  = nat_addr_q;
  assign nat_wdata = nat_wdata_q;
endmodule

// File: rtl/aux_i2c_bridge_chk.sv
module aux_i2c_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_cmd,
  input logic [LEN_W-1:0]  req_len,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic              i2c_req,
  input logic [1:0]        i2c_op,
  input logic              i2c_done,
  input logic              i2c_ack,
  input logic              nat_req,
  input logic [ADDR_W-1:0] nat_addr,
  input logic              nat_done,
  input logic              nat_err
);
  logic              accept, bad_cmd, nat_cmd;
  logic [1:0]        last_op_q;
  logic              nat_seen_q;
  logic [ADDR_W-1:0] last_nat_q;

  assign accept  = req_valid && req_ready;
  assign bad_cmd = !(req_cmd inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9});
  assign nat_cmd = (req_cmd == 4'h8) || (req_cmd == 4'h9);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op_q  <= 2'd0;
      nat_seen_q <= 1'b0;
      last_nat_q <= '0;
    end else begin
      if (i2c_req) last_op_q <= i2c_op;
      if (accept) nat_seen_q <= 1'b0;
      else if (nat_req) begin
        nat_seen_q <= 1'b1;
        last_nat_q <= nat_addr;
      end
    end
  end

  p_bad_nack_r1: assert property (@(posedge clk) disable iff (rst)
    accept && bad_cmd |=> rsp_valid && (rsp_code == 2'b01) && !i2c_req && !nat_req);

  p_nat_step_r2: assert property (@(posedge clk) disable iff (rst)
    nat_req && nat_seen_q |-> nat_addr == last_nat_q + 1'b1);

  p_nat_err_r3: assert property (@(posedge clk) disable iff (rst)
    nat_done && nat_err |=> rsp_valid && (rsp_code == 2'b01) && !nat_req);

  p_zero_nat_r4: assert property (@(posedge clk) disable iff (rst)
    accept && nat_cmd && (req_len == '0) |=> rsp_valid && (rsp_code == 2'b01) && !nat_req);

  // a refused start ends the request at once (R5, and R7 for the continuing form)
  p_start_fail_r5: assert property (@(posedge clk) disable iff (rst)
    i2c_done && (last_op_q == 2'd0) && !i2c_ack |=> rsp_valid && (rsp_code == 2'b01) && !i2c_req);

  // a refused byte is followed by a stop (R6, and R9 for the continuing form)
  p_xfer_fail_stop_r6: assert property (@(posedge clk) disable iff (rst)
    i2c_done && (last_op_q == 2'd1) && !i2c_ack |=> i2c_req && (i2c_op == 2'd2));

  p_one_port_r10: assert property (@(posedge clk) disable iff (rst)
    !(i2c_req && nat_req));

  p_no_defer_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_code != 2'b10);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (i2c_req || nat_req) |-> !req_ready);
endmodule

bind aux_i2c_bridge aux_i2c_bridge_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_cmd  (req_cmd),
  .req_len  (req_len),
  .rsp_valid(rsp_valid),
  .rsp_code (rsp_code),
  .i2c_req  (i2c_req),
  .i2c_op   (i2c_op),
  .i2c_done (i2c_done),
  .i2c_ack  (i2c_ack),
  .nat_req  (nat_req),
  .nat_addr (nat_addr),
  .nat_done (nat_done),
  .nat_err  (nat_err)
);

// File: tb/aux_i2c_bridge_tb_top.sv
module aux_i2c_bridge_tb_top;
  localparam int LOGN = 4096;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic         req_ready;
  logic [3:0]   req_cmd;
  logic [19:0]  req_addr;
  logic [4:0]   req_len;
  logic [127:0] req_wdata;
  logic         rsp_valid;
  logic [1:0]   rsp_code;
  logic [127:0] rsp_rdata;
  logic         i2c_req;
  logic [1:0]   i2c_op;
  logic [6:0]   i2c_addr;
  logic         i2c_rd;
  logic [7:0]   i2c_wdata;
  logic         i2c_done = 1'b0;
  logic         i2c_ack = 1'b0;
  logic [7:0]   i2c_rdata = '0;
  logic         nat_req;
  logic         nat_we;
  logic [19:0]  nat_addr;
  logic [7:0]   nat_wdata;
  logic         nat_done = 1'b0;
  logic         nat_err = 1'b0;
  logic [7:0]   nat_rdata = '0;

  always #5 clk = ~clk;

  aux_i2c_bridge dut_i (.*);

  // ---------------- models ----------------
  logic [15:0] log_q  [LOGN];
  logic [19:0] nlog_q [LOGN];
  int log_n = 0, nlog_n = 0, xfer_cnt = 0;
  int fail_at = -1;
  bit err_en = 0;
  logic [19:0] err_addr = '0;
  logic [7:0] mem [64];

  always @(posedge clk) begin
    i2c_done <= 1'b0;
    if (i2c_req) begin
      i2c_done <= 1'b1;
      log_n <= log_n + 1;
      case (i2c_op)
        2'd0: begin
          i2c_ack  <= (i2c_addr == 7'h50) || (i2c_addr == 7'h51);
          xfer_cnt <= 0;
          log_q[log_n % LOGN] <= {5'b0, 2'd0, i2c_rd, 1'b0, i2c_addr};
        end
        2'd1: begin
          i2c_ack   <= (xfer_cnt != fail_at);
          i2c_rdata <= 8'h30 + 8'(xfer_cnt);
          xfer_cnt  <= xfer_cnt + 1;
          log_q[log_n % LOGN] <= {5'b0, 2'd1, i2c_rd, i2c_rd ? 8'h00 : i2c_wdata};
        end
        default: begin
          i2c_ack <= 1'b1;
          log_q[log_n % LOGN] <= {5'b0, 2'd2, 1'b0, 8'h00};
        end
      endcase
    end
  end

  always @(posedge clk) begin
    nat_done <= 1'b0;
    if (nat_req) begin
      nat_done  <= 1'b1;
      nat_err   <= err_en && (nat_addr == err_addr);
      nat_rdata <= mem[nat_addr[5:0]];
      if (nat_we && !(err_en && (nat_addr == err_addr))) mem[nat_addr[5:0]] <= nat_wdata;
      nlog_q[nlog_n % LOGN] <= nat_addr;
      nlog_n <= nlog_n + 1;
    end
  end

  // ---------------- checking ----------------
  int nchk = 0, nerr = 0;
  int lb, nb;
  logic [1:0]   got_code;
  logic [127:0] got_data;
  logic [15:0]  exp_q [32];
  int exp_n;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] c, input logic [19:0] a, input int len, input logic [127:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lb = log_n; nb = nlog_n;
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = len[4:0]; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_code = rsp_code;
    got_data = rsp_rdata;
  endtask

  task automatic exp_clr(); exp_n = 0; endtask
  task automatic exp_add(input logic [1:0] op, input bit rd, input logic [7:0] b);
    exp_q[exp_n] = {5'b0, op, rd, b};
    exp_n++;
  endtask

  task automatic chk_seq(input string tag);
    bit ok = ((log_n - lb) == exp_n);
    int bad = -1;
    for (int i = 0; ok && i < exp_n; i++)
      if (log_q[(lb + i) % LOGN] != exp_q[i]) begin ok = 0; bad = i; end
    if (bad >= 0) check(ok, {tag, " op"}, log_q[(lb + bad) % LOGN], exp_q[bad]);
    else          check(ok, {tag, " op count"}, log_n - lb, exp_n);
  endtask

  task automatic chk_code(input string tag, input logic [1:0] e);
    check(got_code === e, {tag, " reply"}, got_code, e);
  endtask

  task automatic chk_rd(input string tag, input int len, input logic [7:0] base);
    bit ok = 1;
    for (int i = 0; i < len; i++) if (got_data[i*8 +: 8] !== base + 8'(i)) ok = 0;
    check(ok, {tag, " read data"}, got_data, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  // ---------------- stimulus ----------------
  localparam logic [3:0] NW = 4'h8, NR = 4'h9, PW = 4'h0, PR = 4'h1, MW = 4'h4, MR = 4'h5;

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && i2c_req === 1'b0 && nat_req === 1'b0,
          "R10 reset state", {req_ready, rsp_valid, i2c_req, nat_req}, 4'b1000);

    // R1 / R11: every unrecognised code
    for (int c = 0; c < 16; c++) begin
      if (!(c inside {0, 1, 4, 5, 8, 9})) begin
        run(4'(c), 20'h00050, 2, 128'h1234);
        chk_code("R1 bad cmd", 2'b01);
        check(log_n == lb && nlog_n == nb, "R1 bad cmd bus idle", log_n - lb + nlog_n - nb, 0);
      end
    end

    // R2: native write then read for every length
    for (int len = 1; len <= 16; len++) begin
      logic [19:0] a = 20'h00100 + 20'(len * 3);
      logic [127:0] wd = '0;
      bit ok = 1;
      for (int i = 0; i < 16; i++) wd[i*8 +: 8] = 8'(len * 16 + i);
      run(NW, a, len, wd);
      chk_code("R2 native write", 2'b00);
      if (nlog_n - nb != len) ok = 0;
      for (int i = 0; ok && i < len; i++) if (nlog_q[(nb + i) % LOGN] != a + 20'(i)) ok = 0;
      check(ok, "R2 native address walk", nlog_n - nb, len);
      run(NR, a, len, '0);
      chk_code("R2 native read", 2'b00);
      chk_rd("R2 native", len, 8'(len * 16));
    end
    // R2 address wrap at the top of the space
    begin
      bit ok = 1;
      run(NW, 20'hFFFFD, 5, 128'h0000_0000_0000_0000_0000_00C4_C3C2_C1C0);
      chk_code("R2 wrap write", 2'b00);
      for (int i = 0; i < 5; i++) if (nlog_q[(nb + i) % LOGN] != 20'hFFFFD + 20'(i)) ok = 0;
      check(ok, "R2 wrap addresses", nlog_q[(nb + 3) % LOGN], 20'h00000);
      run(NR, 20'hFFFFD, 5, '0);
      chk_rd("R2 wrap", 5, 8'hC0);
    end

    // R3: error at each of the first four bytes
    err_en = 1;
    for (int k = 0; k < 4; k++) begin
      err_addr = 20'h00200 + 20'(k);
      run(NW, 20'h00200, 6, 128'h0);
      chk_code("R3 native error", 2'b01);
      check(nlog_n - nb == k + 1, "R3 accesses before abort", nlog_n - nb, k + 1);
    end
    err_addr = 20'h00201;
    run(NR, 20'h00200, 4, 128'h0);
    chk_code("R3 native read error", 2'b01);
    check(nlog_n - nb == 2, "R3 read accesses", nlog_n - nb, 2);
    err_en = 0;

    // R4: zero length native
    run(NW, 20'h00300, 0, 128'h0);
    chk_code("R4 zero write", 2'b01);
    check(nlog_n == nb, "R4 zero write no access", nlog_n - nb, 0);
    run(NR, 20'h00300, 0, 128'h0);
    chk_code("R4 zero read", 2'b01);
    check(nlog_n == nb, "R4 zero read no access", nlog_n - nb, 0);

    // R5/R6: plain transfers, bus closed
    run(PW, 20'h00050, 3, 128'h33_22_11);
    exp_clr(); exp_add(0, 0, 8'h50); exp_add(1, 0, 8'h11); exp_add(1, 0, 8'h22); exp_add(1, 0, 8'h33); exp_add(2, 0, 0);
    chk_seq("R6 plain write"); chk_code("R6 plain write", 2'b00);

    run(PR, 20'h00051, 4, '0);
    exp_clr(); exp_add(0, 1, 8'h51); for (int i = 0; i < 4; i++) exp_add(1, 1, 0); exp_add(2, 0, 0);
    chk_seq("R6 plain read"); chk_code("R6 plain read", 2'b00); chk_rd("R6 plain", 4, 8'h30);

    run(PW, 20'h00052, 2, 128'h55_44);
    exp_clr(); exp_add(0, 0, 8'h52);
    chk_seq("R5 start refused"); chk_code("R5 start refused", 2'b01);

    fail_at = 1;
    run(PW, 20'h00050, 3, 128'h33_22_11);
    exp_clr(); exp_add(0, 0, 8'h50); exp_add(1, 0, 8'h11); exp_add(1, 0, 8'h22); exp_add(2, 0, 0);
    chk_seq("R6 byte refused"); chk_code("R6 byte refused", 2'b01);
    fail_at = -1;

    run(PR, 20'h00050, 0, '0);
    exp_clr(); exp_add(0, 1, 8'h50); exp_add(2, 0, 0);
    chk_seq("R6 zero length"); chk_code("R6 zero length", 2'b00);

    // R7: continuing requests from a closed bus
    run(MW, 20'h00052, 1, 128'h77);
    exp_clr(); exp_add(0, 0, 8'h52);
    chk_seq("R7 start refused"); chk_code("R7 start refused", 2'b01);

    run(MW, 20'h00050, 2, 128'hBB_AA);
    exp_clr(); exp_add(0, 0, 8'h50); exp_add(1, 0, 8'hAA); exp_add(1, 0, 8'hBB);
    chk_seq("R7/R9 open no stop"); chk_code("R7 open", 2'b00);

    // R8: same address and command continue
    run(MW, 20'h00050, 1, 128'hCC);
    exp_clr(); exp_add(1, 0, 8'hCC);
    chk_seq("R8 continue"); chk_code("R8 continue", 2'b00);

    // R11: native request in between leaves the transaction alone
    run(NW, 20'h00300, 1, 128'h01);
    run(MW, 20'h00050, 1, 128'hDD);
    exp_clr(); exp_add(1, 0, 8'hDD);
    chk_seq("R11 native between"); chk_code("R11 native between", 2'b00);

    run(MW, 20'h00050, 0, '0);
    exp_clr();
    chk_seq("R8 zero length continue"); chk_code("R8 zero length continue", 2'b00);

    // R8: command change, then address change
    run(MR, 20'h00050, 2, '0);
    exp_clr(); exp_add(2, 0, 0); exp_add(0, 1, 8'h50); exp_add(1, 1, 0); exp_add(1, 1, 0);
    chk_seq("R8 command change"); chk_code("R8 command change", 2'b00); chk_rd("R8 command change", 2, 8'h30);

    run(MR, 20'h00051, 1, '0);
    exp_clr(); exp_add(2, 0, 0); exp_add(0, 1, 8'h51); exp_add(1, 1, 0);
    chk_seq("R8 address change"); chk_code("R8 address change", 2'b00);

    // R5: plain request closes an open transaction first
    run(PW, 20'h00050, 1, 128'hEE);
    exp_clr(); exp_add(2, 0, 0); exp_add(0, 0, 8'h50); exp_add(1, 0, 8'hEE); exp_add(2, 0, 0);
    chk_seq("R5 stop before plain"); chk_code("R5 stop before plain", 2'b00);

    // R9: byte failure in a continuing request
    run(MW, 20'h00050, 1, 128'h11);
    fail_at = 1;
    run(MW, 20'h00050, 3, 128'h99_88_77);
    exp_clr(); exp_add(1, 0, 8'h77); exp_add(2, 0, 0);
    chk_seq("R9 byte refused"); chk_code("R9 byte refused", 2'b01);
    fail_at = -1;
    run(MW, 20'h00050, 1, 128'h22);
    exp_clr(); exp_add(0, 0, 8'h50); exp_add(1, 0, 8'h22);
    chk_seq("R9 closed after failure"); chk_code("R9 reopen", 2'b00);

    // R8: restart to an absent target leaves the bus closed
    run(MW, 20'h00052, 1, 128'h44);
    exp_clr(); exp_add(2, 0, 0); exp_add(0, 0, 8'h52);
    chk_seq("R8 restart refused"); chk_code("R8 restart refused", 2'b01);
    run(MW, 20'h00050, 1, 128'h33);
    exp_clr(); exp_add(0, 0, 8'h50); exp_add(1, 0, 8'h33);
    chk_seq("R7 fresh start"); chk_code("R7 fresh start", 2'b00);

    run(PR, 20'h00050, 1, '0);
    exp_clr(); exp_add(2, 0, 0); exp_add(0, 1, 8'h50); exp_add(1, 1, 0); exp_add(2, 0, 0);
    chk_seq("R6 plain closes"); chk_code("R6 plain closes", 2'b00);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule